// File: doc/BRIEF.md
# Three-Bus Datapath with Hardwired Fetch Control

This block is the datapath and control core of a small CPU organised around three internal buses. Any register may place its value on the first or the second source bus, and the only path into a register is the result bus. A two-input ALU joins the buses: it reads one operand from each source bus and drives the result bus. A register-to-register move is therefore always an ALU pass-through operation. The block holds a program counter, an instruction register, a memory address register, a memory buffer register, a small numbered register file whose entry 0 is hardwired to zero, and a five-bit status register.

A hardwired controller runs the instruction fetch. It uses a fetch/execute phase flag and a three-step counter. In the first step the program counter passes through the ALU into the address register and a read is requested. In the second step the ALU adds a constant one to the program counter while the memory answers, and the memory buffer captures the word. In the third step the buffer passes into the instruction register. A single execute cycle, empty in this block, then hands over to the next fetch, so each instruction takes four cycles.

The memory sits outside the block. It returns the addressed word combinationally on the read-data input while the read strobe is high. The instruction register, the program counter and the status register are visible on debug outputs.

Top module: `tbus_cpu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dbg_pc_o` equals `RESET_PC`, `dbg_ir_o` and `dbg_psr_o` are zero, `mem_rd_o` and `mem_wr_o` are low and `fetch_o` is high.
- R2: The read of each fetch presents, on `mem_addr_o`, the value the program counter held when that fetch started.
- R3: `mem_rd_o` is high for exactly one cycle per fetch, the cycle after the first step, and `mem_wr_o` never rises.
- R4: The program counter advances by one, modulo 2^AW, at the end of the read cycle. It holds its value in every other cycle.
- R5: The word returned during the read cycle appears on `dbg_ir_o` from the execute cycle onward. During the third step `dbg_ir_o` still shows the previous instruction.
- R6: The increment addition updates the status bits from the sum of PC and one. The bit layout is bit0 carry-out, bit1 signed overflow, bit2 zero result, bit3 negative (sum MSB).
- R7: The pass-through steps and the execute cycle leave the status bits unchanged. The interrupt-enable bit (bit4) stays zero.
- R8: `fetch_o` is high for three consecutive cycles and then low for exactly one cycle, so the block repeats with a period of four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | AW | Memory address (memory address register) |
| mem_rd_o | output | 1 | Read strobe; the word must be returned in the same cycle |
| mem_wr_o | output | 1 | Write strobe, held low by the fetch sequence |
| mem_rdata_i | input | DW | Read data from memory |
| mem_wdata_o | output | DW | Write data (memory buffer register) |
| dbg_pc_o | output | AW | Program counter |
| dbg_ir_o | output | DW | Instruction register |
| dbg_psr_o | output | 5 | Status: {I, N, Z, V, C} |
| fetch_o | output | 1 | High in the fetch phase, low in the execute cycle |

## Verification
The program counter is walked from zero through every 8-bit value and past the wrap, with every memory word a distinct affine function of its address. A wrong address, a read that lands one cycle early or late, or an instruction register that loads the wrong word therefore shows up as a value mismatch. The sweep covers the adds that produce signed overflow (0x7F) and carry with a zero result (0xFF), which checks each status bit on its own. The bench samples the status bits in both pass-through steps and in the execute cycle, which separates a flag update tied to the addition from one tied to any ALU activity.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

   typedef enum logic [1:0] {STEP_T0, STEP_T1, STEP_T2} step_e;

   typedef enum logic {PH_EXEC, PH_FETCH} phase_e;

   typedef enum logic [1:0] {ALU_PASS_A, ALU_PASS_B, ALU_ADD} alu_op_e;

   typedef enum logic [1:0] {SRC_A_NONE, SRC_A_PC, SRC_A_RF} src_a_e;

   typedef enum logic [1:0] {SRC_B_NONE, SRC_B_ONE, SRC_B_MBR, SRC_B_RF} src_b_e;

   typedef struct packed {
      src_a_e  src_a;
      src_b_e  src_b;
      alu_op_e op;
      logic    ld_mar;
      logic    ld_pc;
      logic    ld_ir;
      logic    ld_rf;
      logic    rd_req;
   } ctrl_t;

   typedef struct packed {
      logic ie;
      logic neg;
      logic zero;
      logic ovf;
      logic carry;
   } psr_t;

endpackage

// File: rtl/tbus_alu.sv
module tbus_alu
   import tbus_pkg::*;
#(
   parameter int DW = 8
) (
   input  alu_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [DW-1:0]   y,
   output logic            flag_we,
   output psr_t            flags
);
   localparam int MSB = DW - 1;

   logic [DW:0] sum;

   always_comb begin
      sum     = {1'b0, a} + {1'b0, b};
      y       = '0;
      flag_we = 1'b0;
      unique case (op)
         ALU_PASS_A: y = a;
         ALU_PASS_B: y = b;
         ALU_ADD: begin
            y       = sum[DW-1:0];
            flag_we = 1'b1;
         end
         default: y = '0;
      endcase
      flags.ie    = 1'b0;
      flags.carry = sum[DW];
      flags.ovf   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      flags.neg   = sum[MSB];
      flags.zero  = (sum[DW-1:0] == '0);
   end

endmodule

// File: rtl/tbus_regfile.sv
module tbus_regfile #(
   parameter int DW      = 8,
   parameter int NREG    = 8,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [RW-1:0] rd_a_idx,
   input  logic [RW-1:0] rd_b_idx,
   input  logic [RW-1:0] wr_idx,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b
);
   logic [DW-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_entry
      if (g == 0 && ZERO_R0) begin : g_const
         assign regs[g] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (rst)
               regs[g] <= '0;
            else if (wr_en && wr_idx == RW'(g))
               regs[g] <= wr_data;
         end
      end
   end

   assign rd_a = regs[rd_a_idx];
   assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/tbus_ctrl.sv
module tbus_ctrl
   import tbus_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   output ctrl_t ctrl,
   output logic  in_fetch
);
   step_e  step;
   phase_e phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         step  <= STEP_T0;
         phase <= PH_FETCH;
      end else if (phase == PH_EXEC) begin
         phase <= PH_FETCH;
      end else begin
         unique case (step)
            STEP_T0: step <= STEP_T1;
            STEP_T1: step <= STEP_T2;
            default: begin
               step  <= STEP_T0;
               phase <= PH_EXEC;
            end
         endcase
      end
   end

   always_comb begin
      ctrl = '0;
      if (phase == PH_FETCH) begin
         unique case (step)
            STEP_T0: begin
               ctrl.src_a  = SRC_A_PC;
               ctrl.op     = ALU_PASS_A;
               ctrl.ld_mar = 1'b1;
               ctrl.rd_req = 1'b1;
            end
            STEP_T1: begin
               ctrl.src_a = SRC_A_PC;
               ctrl.src_b = SRC_B_ONE;
               ctrl.op    = ALU_ADD;
               ctrl.ld_pc = 1'b1;
            end
            default: begin
               ctrl.src_b = SRC_B_MBR;
               ctrl.op    = ALU_PASS_B;
               ctrl.ld_ir = 1'b1;
            end
         endcase
      end
   end

   assign in_fetch = (phase == PH_FETCH);

endmodule

// File: rtl/tbus_cpu.sv
module tbus_cpu
   import tbus_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          AW       = 8,
   parameter int          NREG     = 8,
   parameter bit          ZERO_R0  = 1'b1,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_rd_o,
   output logic          mem_wr_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic [DW-1:0] mem_wdata_o,
   output logic [AW-1:0] dbg_pc_o,
   output logic [DW-1:0] dbg_ir_o,
   output logic [4:0]    dbg_psr_o,
   output logic          fetch_o
);
   localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;

   if (AW > DW) begin : g_bad_aw
      $error("tbus_cpu: AW must not exceed DW");
   end
   if (DW < 3 * RW) begin : g_bad_dw
      $error("tbus_cpu: DW too narrow for three register indices");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("tbus_cpu: NREG must be at least 2");
   end

   ctrl_t         ctrl;
   logic          in_fetch;
   logic [AW-1:0] pc, mar;
   logic [DW-1:0] mbr, ir;
   logic          rd_pend;
   psr_t          psr;
   logic [DW-1:0] bus1, bus2, bus3;
   logic [DW-1:0] rf_a, rf_b;
   logic          flag_we;
   psr_t          alu_flags;

   tbus_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .ctrl     (ctrl),
      .in_fetch (in_fetch)
   );

   tbus_regfile #(.DW(DW), .NREG(NREG), .ZERO_R0(ZERO_R0)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .rd_a_idx (ir[RW-1:0]),
      .rd_b_idx (ir[2*RW-1:RW]),
      .wr_idx   (ir[3*RW-1:2*RW]),
      .wr_en    (ctrl.ld_rf),
      .wr_data  (bus3),
      .rd_a     (rf_a),
      .rd_b     (rf_b)
   );

   always_comb begin
      unique case (ctrl.src_a)
         SRC_A_PC: bus1 = DW'(pc);
         SRC_A_RF: bus1 = rf_a;
         default:  bus1 = '0;
      endcase
      unique case (ctrl.src_b)
         SRC_B_ONE: bus2 = DW'(1);
         SRC_B_MBR: bus2 = mbr;
         SRC_B_RF:  bus2 = rf_b;
         default:   bus2 = '0;
      endcase
   end

   tbus_alu #(.DW(DW)) u_alu (
      .op      (ctrl.op),
      .a       (bus1),
      .b       (bus2),
      .y       (bus3),
      .flag_we (flag_we),
      .flags   (alu_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc      <= RESET_PC;
         mar     <= '0;
         mbr     <= '0;
         ir      <= '0;
         rd_pend <= 1'b0;
         psr     <= '0;
      end else begin
         rd_pend <= ctrl.rd_req;
         if (ctrl.ld_mar) mar <= bus3[AW-1:0];
         if (ctrl.ld_pc)  pc  <= bus3[AW-1:0];
         if (ctrl.ld_ir)  ir  <= bus3;
         if (rd_pend)     mbr <= mem_rdata_i;
         if (flag_we) begin
            psr.carry <= alu_flags.carry;
            psr.ovf   <= alu_flags.ovf;
            psr.neg   <= alu_flags.neg;
            psr.zero  <= alu_flags.zero;
         end
      end
   end

   assign mem_addr_o  = mar;
   assign mem_rd_o    = rd_pend;
   assign mem_wr_o    = 1'b0;
   assign mem_wdata_o = mbr;
   assign dbg_pc_o    = pc;
   assign dbg_ir_o    = ir;
   assign dbg_psr_o   = psr;
   assign fetch_o     = in_fetch;

endmodule

// File: rtl/tbus_cpu_chk.sv
module tbus_cpu_chk #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_rd_o,
   input logic          mem_wr_o,
   input logic [AW-1:0] dbg_pc_o,
   input logic [DW-1:0] dbg_ir_o,
   input logic [4:0]    dbg_psr_o,
   input logic          fetch_o
);
   // R2: the read addresses the counter value of this fetch
   a_r2_addr_is_pc: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |-> mem_addr_o == dbg_pc_o);

   // R3: read strobe lasts one cycle
   a_r3_rd_single: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |=> !mem_rd_o);

   // R3: no write during fetch
   a_r3_no_write: assert property (@(posedge clk) disable iff (rst)
      !mem_wr_o);

   // R4: counter steps by one after the read cycle
   a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |=> dbg_pc_o == AW'($past(dbg_pc_o) + 1'b1));

   // R4: counter holds otherwise
   a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
      !mem_rd_o |=> $stable(dbg_pc_o));

   // R5: instruction register holds across execute
   a_r5_ir_hold: assert property (@(posedge clk) disable iff (rst)
      !fetch_o |=> $stable(dbg_ir_o));

   // R7: flags change only after the addition
   a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
      !mem_rd_o |=> $stable(dbg_psr_o[3:0]));

   // R7: interrupt enable stays clear
   a_r7_ie_clear: assert property (@(posedge clk) disable iff (rst)
      !dbg_psr_o[4]);

   // R8: execute lasts one cycle
   a_r8_exec_single: assert property (@(posedge clk) disable iff (rst)
      !fetch_o |=> fetch_o);

endmodule

bind tbus_cpu tbus_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mem_addr_o (mem_addr_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .dbg_pc_o   (dbg_pc_o),
   .dbg_ir_o   (dbg_ir_o),
   .dbg_psr_o  (dbg_psr_o),
   .fetch_o    (fetch_o)
);

// File: tb/tbus_cpu_bench.sv
`timescale 1ns/1ps
module tbus_cpu_bench;
   localparam int DW = 8;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, fetch;
   logic [DW-1:0] mem_rdata, mem_wdata, ir;
   logic [AW-1:0] pc;
   logic [4:0]    psr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
      return DW'(a * 8'd37 + 8'd5);
   endfunction

   function automatic logic [4:0] add_flags(input logic [AW-1:0] p);
      logic [7:0] r;
      r = p + 8'd1;
      return {1'b0, r[7], (r == 8'd0), (p == 8'h7F), (p == 8'hFF)};
   endfunction

   assign mem_rdata = mem_rd ? word_at(mem_addr) : 8'hXX;

   tbus_cpu #(.DW(DW), .AW(AW), .NREG(4)) u_tbus_cpu (
      .clk         (clk),
      .rst         (rst),
      .mem_addr_o  (mem_addr),
      .mem_rd_o    (mem_rd),
      .mem_wr_o    (mem_wr),
      .mem_rdata_i (mem_rdata),
      .mem_wdata_o (mem_wdata),
      .dbg_pc_o    (pc),
      .dbg_ir_o    (ir),
      .dbg_psr_o   (psr),
      .fetch_o     (fetch)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      logic [4:0]    flags_prev;
      logic [DW-1:0] ir_prev;
      logic [AW-1:0] p;
      repeat (3) @(negedge clk);
      chk("R1 pc in reset", 32'(pc), 32'h0);
      chk("R1 rd in reset", 32'(mem_rd), 32'h0);
      rst = 1'b0;
      #0.1;
      chk("R1 pc after reset", 32'(pc), 32'h0);
      chk("R1 ir after reset", 32'(ir), 32'h0);
      chk("R1 psr after reset", 32'(psr), 32'h0);
      chk("R1 wr after reset", 32'(mem_wr), 32'h0);
      chk("R1 fetch after reset", 32'(fetch), 32'h1);
      flags_prev = 5'h0;
      ir_prev    = '0;
      p          = '0;
      for (int i = 0; i < 260; i++) begin
         // T0
         chk("R3 no read in T0", 32'(mem_rd), 32'h0);
         chk("R8 fetch in T0", 32'(fetch), 32'h1);
         @(negedge clk);
         // T1
         chk("R3 read in T1", 32'(mem_rd), 32'h1);
         chk("R2 address", 32'(mem_addr), 32'(p));
         chk("R4 pc holds in T1", 32'(pc), 32'(p));
         chk("R7 flags after T0", 32'(psr), 32'(flags_prev));
         chk("R8 fetch in T1", 32'(fetch), 32'h1);
         @(negedge clk);
         // T2
         chk("R3 no read in T2", 32'(mem_rd), 32'h0);
         chk("R3 no write", 32'(mem_wr), 32'h0);
         chk("R4 pc incremented", 32'(pc), 32'(AW'(p + 1'b1)));
         chk("R6 flags from add", 32'(psr), 32'(add_flags(p)));
         chk("R5 ir old in T2", 32'(ir), 32'(ir_prev));
         chk("R8 fetch in T2", 32'(fetch), 32'h1);
         @(negedge clk);
         // execute
         chk("R8 execute cycle", 32'(fetch), 32'h0);
         chk("R5 ir loaded", 32'(ir), 32'(word_at(p)));
         chk("R7 flags after T2", 32'(psr), 32'(add_flags(p)));
         chk("R4 pc holds in execute", 32'(pc), 32'(AW'(p + 1'b1)));
         flags_prev = add_flags(p);
         ir_prev    = word_at(p);
         p          = AW'(p + 1'b1);
         @(negedge clk);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule